// File: doc/BRIEF.md
# Lane-Parallel Integer Multiply-Accumulate by Broadcast Scalar

This block takes one element of a scalar-holding register and broadcasts it across the lanes of a vector operand. Every lane of the operand is multiplied by that scalar, and the low lane-width bits of the product are added to, or subtracted from, the matching lane of an accumulator vector. Lanes are 16 or 32 bits wide. The operation covers one 64-bit register or a pair of 64-bit registers that together make 128 bits.

The block sits in the execute stage of an integer SIMD pipeline. The decoder passes in the raw control fields. The register file supplies the operand pair, the scalar register and the accumulator pair. The block returns the updated accumulator, the register numbers decoded from the fields, and a flag that marks the control word as an invalid encoding. One registered stage separates input from output, and the timing does not depend on the data.

Top module: `scalar_bcast_mac`

## Requirements
- R1: A cycle with `in_valid` high makes `out_valid` high on the next cycle, whatever the data. A cycle with `in_valid` low makes `out_valid` low on the next cycle. Synchronous active-high reset clears `out_valid`, `undef` and `acc_out`.
- R2: `size`=01 selects 16-bit lanes, with 4 lanes in each 64-bit register. The scalar is the 16-bit lane numbered {`m_bit`,`vm[3]`} in `scal_in`, and `scl_idx` = {0,`vm[2:0]`}, so only registers 0 to 7 can be named.
- R3: `size`=10 selects 32-bit lanes, with 2 lanes in each 64-bit register. The scalar is the 32-bit lane numbered `m_bit` in `scal_in`, and `scl_idx` = `vm`.
- R4: `size`=00 or 11 raises `undef` with the result, and `acc_out` keeps its previous value.
- R5: With `q`=1, `undef` is raised if `vd[0]` or `vn[0]` is 1, and `acc_out` keeps its previous value.
- R6: `dst_idx` = {`d_bit`,`vd`} and `src_idx` = {`n_bit`,`vn`}, both registered with the result.
- R7: `op`=0 gives accumulator lane plus product, and `op`=1 gives accumulator lane minus product. The product and the result are both truncated modulo 2^lane-width, so the result is the same whether lanes are read as signed or unsigned.
- R8: Lane e occupies bits [e*w +: w], with lane 0 at the LSB. `q`=0 updates only bits [63:0], and bits [127:64] of `acc_out` take `acc_in[127:64]` unchanged. `q`=1 updates all 128 bits, where the upper register (n+1, d+1) is bits [127:64].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Control word and operands valid |
| size | input | 2 | Lane size field |
| q | input | 1 | 0: 64-bit, 1: 128-bit operation |
| op | input | 1 | 0: accumulate add, 1: accumulate subtract |
| m_bit | input | 1 | Scalar index/register extension bit |
| vm | input | 4 | Scalar register field |
| vn | input | 4 | Source register field |
| vd | input | 4 | Destination register field |
| n_bit | input | 1 | Source register high bit |
| d_bit | input | 1 | Destination register high bit |
| src_in | input | 128 | Vector operand, register n in [63:0], n+1 in [127:64] |
| scal_in | input | 64 | Register holding the scalar |
| acc_in | input | 128 | Accumulator, register d in [63:0], d+1 in [127:64] |
| out_valid | output | 1 | Result valid |
| undef | output | 1 | Invalid-encoding flag for the result |
| acc_out | output | 128 | Updated accumulator |
| dst_idx | output | 5 | Decoded destination register number |
| src_idx | output | 5 | Decoded source register number |
| scl_idx | output | 4 | Decoded scalar register number |

## Verification
Every result lands on the clock edge that follows the cycle in which `in_valid` was presented. This covers `out_valid`, `undef`, `acc_out` and the three register numbers. The bench presents inputs on a falling edge and holds them through one rising edge. It samples every output at the next falling edge, then samples one more falling edge later to confirm that `out_valid` has dropped. For rejected encodings, the expected accumulator is the value the bench last saw on `acc_out`, so a stray write shows up on the same sample.

// File: rtl/scalar_bcast_mac.sv
module scalar_bcast_mac #(
  parameter int REG_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         size,
  input  logic               q,
  input  logic               op,
  input  logic               m_bit,
  input  logic [3:0]         vm,
  input  logic [3:0]         vn,
  input  logic [3:0]         vd,
  input  logic               n_bit,
  input  logic               d_bit,
  input  logic [2*REG_W-1:0] src_in,
  input  logic [REG_W-1:0]   scal_in,
  input  logic [2*REG_W-1:0] acc_in,
  output logic               out_valid,
  output logic               undef,
  output logic [2*REG_W-1:0] acc_out,
  output logic [4:0]         dst_idx,
  output logic [4:0]         src_idx,
  output logic [3:0]         scl_idx
);
  localparam int VEC_W = 2 * REG_W;
  localparam int H_LN  = VEC_W / 16;
  localparam int W_LN  = VEC_W / 32;

  logic [15:0]      scal_h;
  logic [31:0]      scal_w;
  logic [VEC_W-1:0] res_h, res_w, full, nxt;
  logic             bad;

  always_comb begin
    case ({m_bit, vm[3]})
      2'd0:    scal_h = scal_in[15:0];
      2'd1:    scal_h = scal_in[31:16];
      2'd2:    scal_h = scal_in[47:32];
      default: scal_h = scal_in[63:48];
    endcase
  end
  assign scal_w = m_bit ? scal_in[63:32] : scal_in[31:0];

  for (genvar e = 0; e < H_LN; e++) begin : g_h
    logic [15:0] prod;
    assign prod = src_in[e*16 +: 16] * scal_h;
    assign res_h[e*16 +: 16] = op ? acc_in[e*16 +: 16] - prod : acc_in[e*16 +: 16] + prod;
  end

  for (genvar e = 0; e < W_LN; e++) begin : g_w
    logic [31:0] prod;
    assign prod = src_in[e*32 +: 32] * scal_w;
    assign res_w[e*32 +: 32] = op ? acc_in[e*32 +: 32] - prod : acc_in[e*32 +: 32] + prod;
  end

  assign full = (size == 2'b01) ? res_h : res_w;
  assign nxt  = {q ? full[VEC_W-1:REG_W] : acc_in[VEC_W-1:REG_W], full[REG_W-1:0]};
  assign bad  = (size == 2'b00) || (size == 2'b11) || (q && (vd[0] || vn[0]));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      undef     <= 1'b0;
      acc_out   <= '0;
      dst_idx   <= '0;
      src_idx   <= '0;
      scl_idx   <= '0;
    end else begin
      out_valid <= in_valid;
      undef     <= in_valid && bad;
      if (in_valid) begin
        dst_idx <= {d_bit, vd};
        src_idx <= {n_bit, vn};
        scl_idx <= (size == 2'b10) ? vm : {1'b0, vm[2:0]};
        if (!bad) acc_out <= nxt;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
  p_badsize_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (size == 2'b00 || size == 2'b11)) |=> undef);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && undef) |-> $stable(acc_out));
  p_align_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && q && (vd[0] || vn[0])) |=> undef);
  p_dst_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (dst_idx == $past({d_bit, vd}) && src_idx == $past({n_bit, vn})));
  p_upper_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !q && (size == 2'b01 || size == 2'b10))
      |=> acc_out[VEC_W-1:REG_W] == $past(acc_in[VEC_W-1:REG_W]));
endmodule

// File: tb/tb_scalar_bcast_mac.sv
`timescale 1ns/1ps
module tb_scalar_bcast_mac;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [1:0] size = '0;
  logic q = 0, op = 0, m_bit = 0, n_bit = 0, d_bit = 0;
  logic [3:0] vm = '0, vn = '0, vd = '0;
  logic [127:0] src_in = '0, acc_in = '0;
  logic [63:0] scal_in = '0;
  logic out_valid, undef;
  logic [127:0] acc_out;
  logic [4:0] dst_idx, src_idx;
  logic [3:0] scl_idx;
  int checks = 0, errors = 0;
  logic [127:0] last_acc = '0;

  always #2 clk = ~clk;

  scalar_bcast_mac dut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [1:0] sz, input logic qq, input logic oo,
      input logic mm, input logic [3:0] vmm, input logic [127:0] a, input logic [63:0] sc,
      input logic [127:0] acc);
    logic [127:0] r = acc;
    if (sz == 2'b01) begin
      logic [15:0] s = sc[{mm, vmm[3]}*16 +: 16];
      for (int e = 0; e < 8; e++) begin
        logic [15:0] p = a[e*16 +: 16] * s;
        if (qq || e < 4) r[e*16 +: 16] = oo ? acc[e*16 +: 16] - p : acc[e*16 +: 16] + p;
      end
    end else begin
      logic [31:0] s = mm ? sc[63:32] : sc[31:0];
      for (int e = 0; e < 4; e++) begin
        logic [31:0] p = a[e*32 +: 32] * s;
        if (qq || e < 2) r[e*32 +: 32] = oo ? acc[e*32 +: 32] - p : acc[e*32 +: 32] + p;
      end
    end
    return r;
  endfunction

  task automatic run(input logic [1:0] sz, input logic qq, input logic oo, input logic mm,
      input logic [3:0] vmm, input logic [3:0] vnn, input logic [3:0] vdd, input logic nb,
      input logic db, input logic [127:0] a, input logic [63:0] sc, input logic [127:0] acc);
    logic bad = (sz == 2'b00) || (sz == 2'b11) || (qq && (vdd[0] || vnn[0]));
    logic [127:0] exp = bad ? last_acc : model(sz, qq, oo, mm, vmm, a, sc, acc);
    @(negedge clk);
    size = sz; q = qq; op = oo; m_bit = mm; vm = vmm; vn = vnn; vd = vdd;
    n_bit = nb; d_bit = db; src_in = a; scal_in = sc; acc_in = acc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 out_valid", {127'd0, out_valid}, 128'd1);
    chk(bad ? "R4/R5 undef" : "R4/R5 undef clear", {127'd0, undef}, {127'd0, bad});
    chk(bad ? "R4/R5 acc held" : "R7/R8 acc_out", acc_out, exp);
    chk("R6 dst_idx", {123'd0, dst_idx}, {123'd0, db, vdd});
    chk("R6 src_idx", {123'd0, src_idx}, {123'd0, nb, vnn});
    chk(sz == 2'b10 ? "R3 scl_idx" : "R2 scl_idx", {124'd0, scl_idx},
        {124'd0, (sz == 2'b10) ? vmm : {1'b0, vmm[2:0]}});
    last_acc = acc_out;
    @(negedge clk);
    chk("R1 out_valid drop", {127'd0, out_valid}, 128'd0);
  endtask

  task automatic t_reset;
    chk("R1 reset out_valid", {127'd0, out_valid}, 128'd0);
    chk("R1 reset undef", {127'd0, undef}, 128'd0);
    chk("R1 reset acc_out", acc_out, 128'd0);
  endtask

  task automatic t_half_lanes;
    for (int i = 0; i < 4; i++)
      run(2'b01, 1'b0, 1'b0, i[1], {i[0], 3'd5}, 4'd3, 4'd7, 1'b1, 1'b0,
          {$urandom, $urandom, $urandom, $urandom}, 64'h0004_0003_0002_0001,
          {$urandom, $urandom, $urandom, $urandom});
    run(2'b01, 1'b1, 1'b0, 1'b1, 4'hF, 4'd2, 4'd4, 1'b0, 1'b1,
        {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom},
        {$urandom, $urandom, $urandom, $urandom});
  endtask

  task automatic t_word_lanes;
    run(2'b10, 1'b0, 1'b0, 1'b0, 4'hB, 4'd1, 4'd9, 1'b0, 1'b0,
        {$urandom, $urandom, $urandom, $urandom}, 64'h0000_0007_0000_0003,
        {$urandom, $urandom, $urandom, $urandom});
    run(2'b10, 1'b1, 1'b0, 1'b1, 4'hE, 4'd6, 4'd8, 1'b1, 1'b1,
        {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom},
        {$urandom, $urandom, $urandom, $urandom});
  endtask

  task automatic t_sub_wrap;
    run(2'b01, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0,
        {8{16'hFFFF}}, 64'h0000_0000_0000_FFFF, 128'd0);
    run(2'b10, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0, 4'd2, 1'b0, 1'b0,
        {4{32'h8000_0001}}, 64'hFFFF_FFFF_0000_0001, {4{32'h0000_0005}});
    run(2'b10, 1'b0, 1'b0, 1'b0, 4'd3, 4'd4, 4'd4, 1'b0, 1'b0,
        {4{32'hFFFF_FFFF}}, 64'h0000_0000_FFFF_FFFF, {4{32'hFFFF_FFFF}});
  endtask

  task automatic t_bad_size;
    run(2'b00, 1'b0, 1'b0, 1'b0, 4'd1, 4'd1, 4'd1, 1'b0, 1'b0,
        {4{32'h1234_5678}}, 64'h1, {4{32'hAAAA_5555}});
    run(2'b11, 1'b1, 1'b1, 1'b1, 4'd2, 4'd2, 4'd2, 1'b1, 1'b1,
        {4{32'h1}}, 64'h3, 128'd77);
  endtask

  task automatic t_align;
    run(2'b01, 1'b1, 1'b0, 1'b0, 4'd1, 4'd2, 4'd3, 1'b0, 1'b0,
        {4{32'h0101_0101}}, 64'h9, {4{32'hCAFE_F00D}});
    run(2'b10, 1'b1, 1'b0, 1'b0, 4'd1, 4'd5, 4'd6, 1'b0, 1'b0,
        {4{32'h0101_0101}}, 64'h9, {4{32'hCAFE_F00D}});
    run(2'b10, 1'b0, 1'b1, 1'b0, 4'd1, 4'd5, 4'd7, 1'b0, 1'b1,
        {4{32'h0000_0002}}, 64'h3, {4{32'h0000_0010}});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_half_lanes();
    t_word_lanes();
    t_sub_wrap();
    t_bad_size();
    t_align();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule